// File: doc/BRIEF.md
# Store Write-Policy Controller

This block sits beside a data cache and settles, for every store, which of three paths it takes. A store that hits a line the cache owns outright is written locally. A store that hits a line held in common with other agents is written both to the cache and to memory through a writethrough bus cycle, and the bus reply chooses the line's resulting state. A store that misses either goes out as a plain memory write, or, when allocation is switched on and the address is eligible, turns into a line fill followed by a store hit on the freshly filled line.

Eligibility is checked per store against a set of address windows. Each window has an inclusive lower bound, an inclusive upper bound and an enable bit. The tag lookup result for the store arrives together with its address. The block never moves line data; it only asks the bus for cycles and tells the cache array when to write the store data and what state to record.

Two handshakes sit at the edges. The store channel accepts a store on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is high only while no store is in flight, so a producer must hold a store steady until it is taken. The bus request channel raises `bus_valid` and then keeps `bus_op` and `bus_addr` unchanged until a cycle in which `bus_ready` is high. The bus may hold `bus_ready` low for any number of cycles, and it may lower `bus_ready` in reply to `bus_valid`. Completion of an issued cycle is a one-cycle `bus_done` pulse. The reply attribute travels on `bus_excl` in that same cycle.

Top module: `store_policy_ctrl`

## Requirements
- R1: A store accepted with line state M (3) or E (2) gives, one cycle after acceptance, a single-cycle `cw_valid` and `cs_valid` with `cs_state` = M (3) and `cw_addr` equal to the store address, and no bus request.
- R2: A store accepted with line state S (1) issues a bus request with `bus_op` = 2 (writethrough) at the store address. The cycle after its `bus_done`, it gives `cw_valid` and `cs_valid` with `cs_state` = E (2) if `bus_excl` was 1 at completion, or S (1) if it was 0.
- R3: A store accepted with line state I (0) that is not allocatable issues one bus request with `bus_op` = 1 (plain write) and never raises `cw_valid` or `cs_valid`. `st_ready` returns the cycle after `bus_done`.
- R4: A store accepted with line state I (0) that is allocatable first issues a bus request with `bus_op` = 3 (line fill) at the store address.
- R5: When a fill completes with `bus_excl` = 1, the filled line counts as E, and the store then finishes as in R1 with no further bus request. When it completes with `bus_excl` = 0, the line counts as S, and the store then finishes as in R2, including a writethrough request.
- R6: A miss is allocatable only when `wa_mode` is 1 and the address lies within `[base, limit]`, both ends inclusive, of at least one range whose enable bit is 1. Range g takes bits `[g*AW +: AW]` of `rng_base` and `rng_limit` and bit g of `rng_en`. Disabled ranges are ignored.
- R7: `bus_valid` stays high with `bus_op` and `bus_addr` unchanged until `bus_ready` is seen. `st_ready` is low from the cycle after acceptance until the store completes.
- R8: A `bus_done` pulse has no effect unless a bus cycle has been handed off and is awaiting completion. This holds both while idle and while a request is still waiting for `bus_ready`.
- R9: During and straight after reset, `st_ready` is 1 and `bus_valid`, `cw_valid` and `cs_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted (controller idle) |
| st_addr | input | AW | Store address |
| st_line | input | 2 | Lookup state of the addressed line: 0 I, 1 S, 2 E, 3 M |
| wa_mode | input | 1 | Allocate-on-store-miss mode enable |
| rng_base | input | NR*AW | Inclusive lower bounds of the eligibility windows |
| rng_limit | input | NR*AW | Inclusive upper bounds of the eligibility windows |
| rng_en | input | NR | Per-window enable |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Bus takes the request |
| bus_op | output | 2 | Cycle kind: 1 write, 2 writethrough, 3 line fill |
| bus_addr | output | AW | Cycle address |
| bus_done | input | 1 | Handed-off cycle finished (one-cycle pulse) |
| bus_excl | input | 1 | Reply attribute: line may be held exclusively |
| cw_valid | output | 1 | Write the store data into the cache line |
| cw_addr | output | AW | Address for the cache write and state update |
| cs_valid | output | 1 | Record a new line state |
| cs_state | output | 2 | Line state to record |

## Verification
The bench aims at the window edges: addresses exactly on the lower and upper bounds, one past the upper bound, and inside a disabled window. A comparator that is off by one, or that skips the enable bit, would send a fill where a plain write belongs, or the reverse. It runs both fill outcomes. A design that ignored the fill reply would either skip the writethrough owed to a shared fill or add a bus cycle to an exclusive one. It also pulses `bus_done` while idle, and while a writethrough waits on a stalled `bus_ready` with `bus_excl` set opposite to the real reply. A design that took that early pulse would finish too soon and record the wrong state. Stalls on `bus_ready` check that the request is held without change.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_NONE  = 2'd0,
    BOP_WRITE = 2'd1,
    BOP_WTHRU = 2'd2,
    BOP_FILL  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    ACT_LOCAL = 2'd0,
    ACT_WTHRU = 2'd1,
    ACT_WRITE = 2'd2,
    ACT_FILL  = 2'd3
  } store_act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOCAL,
    ST_WT_REQ,
    ST_WT_WAIT,
    ST_WT_FIN,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_FL_REQ,
    ST_FL_WAIT
  } ctl_st_e;

endpackage

// File: rtl/sp_range_match.sv
module sp_range_match #(
  parameter int AW = 32,
  parameter int NR = 3
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NR*AW-1:0] base_i,
  input  logic [NR*AW-1:0] limit_i,
  input  logic [NR-1:0]    en_i,
  output logic             hit_o
);

  logic [NR-1:0] win_hit;

  for (genvar g = 0; g < NR; g++) begin : g_win
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    assign lo = base_i[g*AW +: AW];
    assign hi = limit_i[g*AW +: AW];
    assign win_hit[g] = en_i[g] && (addr_i >= lo) && (addr_i <= hi);
  end

  assign hit_o = |win_hit;

endmodule

// File: rtl/sp_classify.sv
module sp_classify
  import sp_pkg::*;
(
  input  logic [1:0] line_i,
  input  logic       wa_mode_i,
  input  logic       in_range_i,
  output store_act_e act_o
);

  always_comb begin
    unique case (line_i)
      LS_M, LS_E: act_o = ACT_LOCAL;
      LS_S:       act_o = ACT_WTHRU;
      default:    act_o = (wa_mode_i && in_range_i) ? ACT_FILL : ACT_WRITE;
    endcase
  end

endmodule

// File: rtl/sp_fsm.sv
module sp_fsm
  import sp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [1:0]    st_line_i,
  input  logic          wa_mode_i,
  input  store_act_e    act_i,
  output logic          bus_valid_o,
  input  logic          bus_ready_i,
  output logic [1:0]    bus_op_o,
  output logic [AW-1:0] bus_addr_o,
  input  logic          bus_done_i,
  input  logic          bus_excl_i,
  output logic          cw_valid_o,
  output logic [AW-1:0] cw_addr_o,
  output logic          cs_valid_o,
  output logic [1:0]    cs_state_o
);

  ctl_st_e       state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          excl_q;
  logic          accept;

  assign accept = st_valid_i && st_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (st_valid_i) begin
          unique case (act_i)
            ACT_LOCAL: state_d = ST_LOCAL;
            ACT_WTHRU: state_d = ST_WT_REQ;
            ACT_FILL:  state_d = ST_FL_REQ;
            default:   state_d = ST_WR_REQ;
          endcase
        end
      end
      ST_LOCAL:   state_d = ST_IDLE;
      ST_WT_REQ:  if (bus_ready_i) state_d = ST_WT_WAIT;
      ST_WT_WAIT: if (bus_done_i) state_d = ST_WT_FIN;
      ST_WT_FIN:  state_d = ST_IDLE;
      ST_WR_REQ:  if (bus_ready_i) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (bus_done_i) state_d = ST_IDLE;
      ST_FL_REQ:  if (bus_ready_i) state_d = ST_FL_WAIT;
      ST_FL_WAIT: if (bus_done_i) state_d = bus_excl_i ? ST_LOCAL : ST_WT_REQ;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      excl_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= st_addr_i;
      if (state_q == ST_WT_WAIT && bus_done_i) excl_q <= bus_excl_i;
    end
  end

  always_comb begin
    st_ready_o  = (state_q == ST_IDLE);
    bus_valid_o = 1'b0;
    bus_op_o    = BOP_NONE;
    unique case (state_q)
      ST_WT_REQ: begin bus_valid_o = 1'b1; bus_op_o = BOP_WTHRU; end
      ST_WR_REQ: begin bus_valid_o = 1'b1; bus_op_o = BOP_WRITE; end
      ST_FL_REQ: begin bus_valid_o = 1'b1; bus_op_o = BOP_FILL;  end
      default: ;
    endcase
    cw_valid_o = (state_q == ST_LOCAL) || (state_q == ST_WT_FIN);
    cs_valid_o = cw_valid_o;
    if (state_q == ST_LOCAL) cs_state_o = LS_M;
    else                     cs_state_o = excl_q ? LS_E : LS_S;
  end

  assign bus_addr_o = addr_q;
  assign cw_addr_o  = addr_q;

  AST_LOCAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (st_line_i == LS_M || st_line_i == LS_E)
    |=> cw_valid_o && cs_valid_o && cs_state_o == LS_M && !bus_valid_o); // R1

  AST_SHARED_WT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && st_line_i == LS_S |=> bus_valid_o && bus_op_o == BOP_WTHRU); // R2

  AST_PLAIN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && st_line_i == LS_I && !wa_mode_i
    |=> bus_valid_o && bus_op_o == BOP_WRITE); // R3

  AST_ALLOC_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && act_i == ACT_FILL |=> bus_valid_o && bus_op_o == BOP_FILL); // R4

  AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FL_WAIT && bus_done_i && bus_excl_i
    |=> cs_valid_o && cs_state_o == LS_M && !bus_valid_o); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && !bus_ready_i
    |=> bus_valid_o && $stable(bus_op_o) && $stable(bus_addr_o)); // R7

  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> !st_ready_o); // R7

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready_o && !st_valid_i && bus_done_i |=> st_ready_o && !bus_valid_o); // R8

endmodule

// File: rtl/store_policy_ctrl.sv
module store_policy_ctrl
  import sp_pkg::*;
#(
  parameter int AW = 32,
  parameter int NR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [AW-1:0]    st_addr,
  input  logic [1:0]       st_line,
  input  logic             wa_mode,
  input  logic [NR*AW-1:0] rng_base,
  input  logic [NR*AW-1:0] rng_limit,
  input  logic [NR-1:0]    rng_en,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [1:0]       bus_op,
  output logic [AW-1:0]    bus_addr,
  input  logic             bus_done,
  input  logic             bus_excl,
  output logic             cw_valid,
  output logic [AW-1:0]    cw_addr,
  output logic             cs_valid,
  output logic [1:0]       cs_state
);

  logic       in_range;
  store_act_e act;

  sp_range_match #(.AW(AW), .NR(NR)) u_range (
    .addr_i  (st_addr),
    .base_i  (rng_base),
    .limit_i (rng_limit),
    .en_i    (rng_en),
    .hit_o   (in_range)
  );

  sp_classify u_class (
    .line_i     (st_line),
    .wa_mode_i  (wa_mode),
    .in_range_i (in_range),
    .act_o      (act)
  );

  sp_fsm #(.AW(AW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid_i  (st_valid),
    .st_ready_o  (st_ready),
    .st_addr_i   (st_addr),
    .st_line_i   (st_line),
    .wa_mode_i   (wa_mode),
    .act_i       (act),
    .bus_valid_o (bus_valid),
    .bus_ready_i (bus_ready),
    .bus_op_o    (bus_op),
    .bus_addr_o  (bus_addr),
    .bus_done_i  (bus_done),
    .bus_excl_i  (bus_excl),
    .cw_valid_o  (cw_valid),
    .cw_addr_o   (cw_addr),
    .cs_valid_o  (cs_valid),
    .cs_state_o  (cs_state)
  );

  AST_RANGE_GATES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_line == LS_I && !in_range
    |=> bus_op == BOP_WRITE); // R6

endmodule

// File: tb/store_policy_ctrl_tb_top.sv
module store_policy_ctrl_tb_top;
  localparam int AW = 32;
  localparam int NR = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             st_valid = 1'b0;
  logic             st_ready;
  logic [AW-1:0]    st_addr = '0;
  logic [1:0]       st_line = 2'd0;
  logic             wa_mode = 1'b0;
  logic [NR*AW-1:0] rng_base;
  logic [NR*AW-1:0] rng_limit;
  logic [NR-1:0]    rng_en;
  logic             bus_valid;
  logic             bus_ready = 1'b0;
  logic [1:0]       bus_op;
  logic [AW-1:0]    bus_addr;
  logic             bus_done = 1'b0;
  logic             bus_excl = 1'b0;
  logic             cw_valid;
  logic [AW-1:0]    cw_addr;
  logic             cs_valid;
  logic [1:0]       cs_state;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R9";
  logic [47:0] exp_q[$];

  always #10 clk = ~clk;

  store_policy_ctrl #(.AW(AW), .NR(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_line(st_line), .wa_mode(wa_mode),
    .rng_base(rng_base), .rng_limit(rng_limit), .rng_en(rng_en),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_done(bus_done), .bus_excl(bus_excl),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cs_valid(cs_valid),
    .cs_state(cs_state)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] ev(input logic [7:0] kind, input logic [7:0] val,
                                      input logic [31:0] a);
    return {kind, val, a};
  endfunction

  // kind 1: bus handshake (val=op); kind 2: cache write + state (val=state); kind 3: lone half
  task automatic exp_bus(input logic [1:0] op, input logic [31:0] a);
    exp_q.push_back(ev(8'd1, {6'd0, op}, a));
  endtask
  task automatic exp_upd(input logic [1:0] s, input logic [31:0] a);
    exp_q.push_back(ev(8'd2, {6'd0, s}, a));
  endtask

  task automatic observe(input logic [47:0] got);
    if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected event", {16'd0, got}, 64'd0);
    else begin
      logic [47:0] want;
      want = exp_q.pop_front();
      check(got == want, cur_req, "event", {16'd0, got}, {16'd0, want});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid && bus_ready) observe(ev(8'd1, {6'd0, bus_op}, bus_addr));
      if (cw_valid || cs_valid)
        observe(ev((cw_valid && cs_valid) ? 8'd2 : 8'd3, {6'd0, cs_state}, cw_addr));
    end
  end

  // resp[i] is bus_excl for the i-th bus cycle; stray pulses an early done while stalled
  task automatic do_store(input logic [31:0] a, input logic [1:0] ls, input int nbus,
                          input logic [3:0] resp, input int dly, input bit stray);
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_line = ls;
    @(posedge clk); #1;
    st_valid = 1'b0;
    check(st_ready == 1'b0, "R7", "st_ready low after accept", {63'd0, st_ready}, 64'd0);
    for (int i = 0; i < nbus; i++) begin
      while (!bus_valid) begin @(posedge clk); #1; end
      for (int d = 0; d < dly; d++) begin
        if (stray && i == 0 && d == 0) begin bus_done = 1'b1; bus_excl = ~resp[i]; end
        @(posedge clk); #1;
        bus_done = 1'b0; bus_excl = 1'b0;
      end
      if (stray && i == 0)
        check(bus_valid == 1'b1, "R8", "request kept after early done", {63'd0, bus_valid}, 64'd1);
      bus_ready = 1'b1;
      @(posedge clk); #1;
      bus_ready = 1'b0;
      @(posedge clk); #1;
      bus_done = 1'b1; bus_excl = resp[i];
      @(posedge clk); #1;
      bus_done = 1'b0; bus_excl = 1'b0;
    end
    while (!st_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    check(exp_q.size() == 0, cur_req, "all expected events seen", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    rng_base  = {32'h0000_4000, 32'h0000_8000, 32'h0000_1000};
    rng_limit = {32'h0000_4FFF, 32'h0000_80FF, 32'h0000_1FFF};
    rng_en    = 3'b011;
    repeat (3) @(posedge clk);
    #1;
    check(st_ready == 1'b1, "R9", "ready in reset", {63'd0, st_ready}, 64'd1);
    check(!bus_valid && !cw_valid && !cs_valid, "R9", "quiet in reset",
          {61'd0, bus_valid, cw_valid, cs_valid}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(st_ready == 1'b1 && !bus_valid, "R9", "idle after reset",
          {62'd0, st_ready, bus_valid}, 64'd2);

    cur_req = "R1"; exp_upd(2'd3, 32'h100);
    do_store(32'h100, 2'd3, 0, 4'd0, 0, 1'b0);
    cur_req = "R1"; exp_upd(2'd3, 32'h104);
    do_store(32'h104, 2'd2, 0, 4'd0, 0, 1'b0);

    cur_req = "R2"; exp_bus(2'd2, 32'h200); exp_upd(2'd2, 32'h200);
    do_store(32'h200, 2'd1, 1, 4'b0001, 0, 1'b0);
    cur_req = "R2"; exp_bus(2'd2, 32'h204); exp_upd(2'd1, 32'h204);
    do_store(32'h204, 2'd1, 1, 4'b0000, 3, 1'b0);

    cur_req = "R3"; wa_mode = 1'b0; exp_bus(2'd1, 32'h1100);
    do_store(32'h1100, 2'd0, 1, 4'd0, 0, 1'b0);
    cur_req = "R3"; wa_mode = 1'b1; exp_bus(2'd1, 32'h3000);
    do_store(32'h3000, 2'd0, 1, 4'd0, 2, 1'b0);

    cur_req = "R4"; exp_bus(2'd3, 32'h1200); exp_upd(2'd3, 32'h1200);
    do_store(32'h1200, 2'd0, 1, 4'b0001, 0, 1'b0);
    cur_req = "R5"; exp_bus(2'd3, 32'h8010); exp_bus(2'd2, 32'h8010); exp_upd(2'd2, 32'h8010);
    do_store(32'h8010, 2'd0, 2, 4'b0010, 1, 1'b0);
    cur_req = "R5"; exp_bus(2'd3, 32'h8020); exp_bus(2'd2, 32'h8020); exp_upd(2'd1, 32'h8020);
    do_store(32'h8020, 2'd0, 2, 4'b0000, 0, 1'b0);

    cur_req = "R6"; exp_bus(2'd1, 32'h4800);
    do_store(32'h4800, 2'd0, 1, 4'd0, 0, 1'b0);
    cur_req = "R6"; exp_bus(2'd3, 32'h1FFF); exp_upd(2'd3, 32'h1FFF);
    do_store(32'h1FFF, 2'd0, 1, 4'b0001, 0, 1'b0);
    cur_req = "R6"; exp_bus(2'd3, 32'h1000); exp_upd(2'd3, 32'h1000);
    do_store(32'h1000, 2'd0, 1, 4'b0001, 0, 1'b0);
    cur_req = "R6"; exp_bus(2'd1, 32'h2000);
    do_store(32'h2000, 2'd0, 1, 4'd0, 0, 1'b0);
    cur_req = "R6"; exp_bus(2'd1, 32'h8100);
    do_store(32'h8100, 2'd0, 1, 4'd0, 0, 1'b0);

    cur_req = "R8";
    bus_done = 1'b1; bus_excl = 1'b1;
    @(posedge clk); #1;
    bus_done = 1'b0; bus_excl = 1'b0;
    @(posedge clk); #1;
    check(st_ready == 1'b1 && !bus_valid && !cs_valid, "R8", "idle done ignored",
          {61'd0, st_ready, bus_valid, cs_valid}, 64'd4);
    exp_bus(2'd2, 32'h300); exp_upd(2'd1, 32'h300);
    do_store(32'h300, 2'd1, 1, 4'b0000, 3, 1'b1);

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R7", "no leftover events", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule